// File: doc/BRIEF.md
# Serial-Controlled Clock Output Gate

This block is a two-wire serial slave that holds the enable bits for a bank of fanned-out clock outputs. A bus master uses it to switch single clock outputs on or off. The slave answers two device addresses. One address selects register-pointer semantics with random and sequential access. The other selects block semantics, where a command code and a byte count come before the data and the transfer always starts at the first register. The register pointer wraps from the last register back to the first. A write takes effect at the acknowledge of its data byte, without waiting for STOP.

The bus lines arrive as slow, oversampled levels. They are synchronized and edge-detected on a fast system clock. The slave returns a single open-drain pull-low request for SDA. That request changes only a few system cycles after a detected SCL fall, which provides data hold time. A thin gating stage follows the register image. It passes the reference clock to each enabled output and holds each disabled output low. It turns off every pad driver when the board-level drive enable is low.

Top module: `clk_fanout_ctl`

## Requirements
- R1: The slave acknowledges device address 7'b1101001 (block mode) and 7'b1011000 or 7'b1011100 (pointer mode; address bit 2 is ignored). The address byte is sent MSB first, with the read/write bit last (1 = read). Any other address is not acknowledged, and every byte after it is ignored until the next START.
- R2: After synchronous active-low reset, `sda_pull` is 0 and `ctl_image` is 24'hC0FFFF.
- R3: `ctl_image[7:0]` is register 0 and enables outputs 7..0. `ctl_image[15:8]` is register 1 and enables outputs 15..8. `ctl_image[23:16]` is register 2: bit 7 enables output 17, bit 6 enables output 16, and bits 5..0 always read and hold 0.
- R4: In pointer mode, the first byte after a write address loads the pointer. A value of 3 or more loads 0. Each following data byte goes to the register under the pointer, and the pointer then increments from 2 back to 0.
- R5: A data byte updates its register at the SCL fall that starts its acknowledge, before any STOP. A STOP or START that arrives before the eighth bit of a byte discards that byte.
- R6: A pointer-mode read after a repeated START sends registers MSB first from the pointer, incrementing and wrapping after each byte. A master NACK ends the read and releases SDA.
- R7: A block-mode write address resets the pointer to 0. A command byte of 8'h00 is acknowledged, the next byte (the count) is acknowledged and ignored, and data bytes then fill registers 0, 1 and 2 in order.
- R8: In block mode, a command byte other than 8'h00 is not acknowledged, and the following bytes are ignored until the next START.
- R9: A block-mode read after the zero command sends a count slot of value 8'h03 first, then registers from 0 upward.
- R10: With `drive_en` = 1, every `pad_oe` bit is 1 and each `clk_out[n]` equals `ref_clk` AND its enable bit. With `drive_en` = 0, every `pad_oe` bit and every `clk_out` bit is 0.
- R11: `sda_pull` changes only while SCL is low, never during an SCL high period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 = pull SDA low (open drain) |
| ref_clk | input | 1 | Reference clock that is fanned out |
| drive_en | input | 1 | 1 = output pads driven, 0 = all tristated |
| ctl_image | output | 24 | Register image {reg2, reg1, reg0} |
| clk_out | output | 18 | Gated clock outputs |
| pad_oe | output | 18 | Per-output pad driver enable |

## Verification
The bench builds the block with its default parameters. Eighteen outputs give three registers with only two used bits in the last one, so the bench can reach pointer wrap after register 2, masking of the reserved bits, and the out-of-range pointer clamp. The default hold delay of three cycles, together with a two-flop synchronizer, keeps every data change well inside the SCL low period that the bench drives. This lets the per-clock comparison of the image and the gated outputs hold right up to each acknowledge.

// File: rtl/fcs_pkg.sv
// Shared types for the serial clock-gate control slave.
// Assumes: nothing beyond IEEE 1800-2017.
package fcs_pkg;
    typedef enum logic [2:0] {
        LK_IDLE,   // waiting for a START
        LK_ADDR,   // receiving device address
        LK_PTR,    // pointer byte (pointer mode) or command byte (block mode)
        LK_CNT,    // block-mode write byte count, ignored
        LK_WR,     // receiving data bytes
        LK_RCNT,   // block-mode read count slot
        LK_RD      // transmitting register data
    } lk_state_t;
endpackage

// File: rtl/fcs_line_sync.sv
// Synchronizes one bus line into the system clock domain and flags its edges.
// Assumes: STAGES >= 2; the idle bus level is high.
module fcs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    // shift the raw level through the synchronizer and keep the last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
            prev <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], raw};
            prev <= pipe[STAGES-1];
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/fcs_link.sv
// Byte engine and protocol state machine of the two-wire slave; owns the registers.
// Assumes: edge and condition strobes are one system cycle wide and in one domain.
module fcs_link
    import fcs_pkg::*;
#(
    parameter int              NREG      = 3,
    parameter logic [6:0]      SMB_ADDR  = 7'h69,
    parameter logic [6:0]      I2C_ADDR  = 7'h58,
    parameter logic [6:0]      I2C_DC    = 7'h04,
    parameter logic [7:0]      LAST_MASK = 8'hC0,
    parameter logic [8*NREG-1:0] RST_IMG = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            sda_lvl,
    input  logic            bus_start,
    input  logic            bus_stop,
    output logic            drive_req,
    output logic [8*NREG-1:0] image
);
    localparam int PW = $clog2(NREG);

    lk_state_t              st;
    logic [3:0]             cnt;
    logic [7:0]             sh;
    logic                   ack_slot, ack_mine, mack, smb;
    logic [PW-1:0]          ptr, ptr_inc;
    logic [NREG-1:0][7:0]   regs;
    logic                   is_tx, load_cnt, addr_smb, addr_i2c;
    logic [7:0]             tx_byte, wmask;

    // decode helpers for the current byte and pointer
    always_comb begin
        is_tx    = (st == LK_RCNT) || (st == LK_RD);
        load_cnt = (st == LK_RCNT) && ack_mine;
        tx_byte  = load_cnt ? 8'(NREG) : regs[ptr];
        ptr_inc  = (ptr == PW'(NREG - 1)) ? '0 : ptr + 1'b1;
        wmask    = (ptr == PW'(NREG - 1)) ? LAST_MASK : 8'hFF;
        addr_smb = (sh[7:1] == SMB_ADDR);
        addr_i2c = ((sh[7:1] & ~I2C_DC) == (I2C_ADDR & ~I2C_DC));
    end

    // protocol sequencing, bit shifting and register commits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LK_IDLE; cnt <= '0; sh <= '0; ack_slot <= 1'b0;
            ack_mine <= 1'b0; mack <= 1'b0; smb <= 1'b0; ptr <= '0;
            drive_req <= 1'b0; regs <= RST_IMG;
        end else if (bus_start) begin
            st <= LK_ADDR; cnt <= '0; ack_slot <= 1'b0; drive_req <= 1'b0;
        end else if (bus_stop) begin
            st <= LK_IDLE; ack_slot <= 1'b0; drive_req <= 1'b0;
        end else if (st != LK_IDLE) begin
            if (scl_rise) begin
                if (!ack_slot) begin
                    cnt <= cnt + 1'b1;
                    if (!is_tx) sh <= {sh[6:0], sda_lvl};
                end else if (!ack_mine) begin
                    mack <= ~sda_lvl;
                end
            end else if (scl_fall) begin
                if (ack_slot) begin
                    ack_slot <= 1'b0; cnt <= '0; drive_req <= 1'b0;
                    if (is_tx) begin
                        if (ack_mine || mack) begin
                            sh <= tx_byte;
                            drive_req <= ~tx_byte[7];
                            if (!load_cnt) begin
                                ptr <= ptr_inc;
                                st  <= LK_RD;
                            end
                        end else begin
                            st <= LK_IDLE;
                        end
                    end
                end else if (cnt == 4'd8) begin
                    ack_slot <= 1'b1;
                    if (is_tx) begin
                        drive_req <= 1'b0; ack_mine <= 1'b0; mack <= 1'b0;
                    end else begin
                        ack_mine  <= 1'b1;
                        drive_req <= 1'b1;
                        case (st)
                            LK_ADDR: begin
                                if (addr_smb) begin
                                    smb <= 1'b1; ptr <= '0;
                                    st  <= sh[0] ? LK_RCNT : LK_PTR;
                                end else if (addr_i2c) begin
                                    smb <= 1'b0;
                                    st  <= sh[0] ? LK_RD : LK_PTR;
                                end else begin
                                    st <= LK_IDLE; drive_req <= 1'b0; ack_slot <= 1'b0;
                                end
                            end
                            LK_PTR: begin
                                if (smb) begin
                                    if (sh == 8'h00) st <= LK_CNT;
                                    else begin
                                        st <= LK_IDLE; drive_req <= 1'b0; ack_slot <= 1'b0;
                                    end
                                end else begin
                                    ptr <= (sh < 8'(NREG)) ? sh[PW-1:0] : '0;
                                    st  <= LK_WR;
                                end
                            end
                            LK_CNT: st <= LK_WR;
                            LK_WR: begin
                                regs[ptr] <= sh & wmask;
                                ptr       <= ptr_inc;
                            end
                            default: st <= LK_IDLE;
                        endcase
                    end
                end else if (is_tx) begin
                    sh        <= {sh[6:0], 1'b0};
                    drive_req <= ~sh[6];
                end
            end
        end
    end

    assign image = regs;
endmodule

// File: rtl/fcs_sda_hold.sv
// Applies the requested SDA pull a fixed number of cycles after each SCL fall.
// Assumes: HOLD >= 1 and the SCL low period exceeds HOLD plus synchronizer delay.
module fcs_sda_hold #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_fall,
    input  logic req,
    output logic sda_pull
);
    localparam int TW = $clog2(HOLD + 1);
    logic [TW-1:0] tmr;

    // count down from each SCL fall and then copy the request to the pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr      <= '0;
            sda_pull <= 1'b0;
        end else if (scl_fall) begin
            tmr <= TW'(HOLD);
        end else if (tmr != '0) begin
            tmr <= tmr - 1'b1;
            if (tmr == TW'(1)) sda_pull <= req;
        end
    end
endmodule

// File: rtl/fcs_gate.sv
// Gates the reference clock onto each output from its register enable bit.
// Assumes: outputs beyond the full registers map to the top bits of the last one.
module fcs_gate #(
    parameter int NOUT = 18,
    parameter int NREG = 3
) (
    input  logic              ref_clk,
    input  logic              drive_en,
    input  logic [8*NREG-1:0] image,
    output logic [NOUT-1:0]   clk_out,
    output logic [NOUT-1:0]   pad_oe
);
    localparam int LOWN = 8 * (NREG - 1);
    localparam int USED = NOUT - LOWN;

    for (genvar k = 0; k < NOUT; k++) begin : g_out
        localparam int IDX = (k < LOWN) ? k : LOWN + (8 - USED) + (k - LOWN);
        // one output: clock when enabled, low when disabled, quiet when pads are off
        assign clk_out[k] = drive_en & ref_clk & image[IDX];
        assign pad_oe[k]  = drive_en;
    end
endmodule

// File: rtl/clk_fanout_ctl.sv
// Top: serial control slave with two address personalities plus the clock gate.
// Assumes: clk oversamples SCL by well over 2*(SYNC+HOLD) cycles per phase.
module clk_fanout_ctl #(
    parameter int         NOUT     = 18,
    parameter int         SYNC     = 2,
    parameter int         HOLD     = 3,
    parameter logic [6:0] SMB_ADDR = 7'h69,
    parameter logic [6:0] I2C_ADDR = 7'h58,
    parameter logic [6:0] I2C_DC   = 7'h04
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_pull,
    input  logic                       ref_clk,
    input  logic                       drive_en,
    output logic [8*((NOUT+7)/8)-1:0]  ctl_image,
    output logic [NOUT-1:0]            clk_out,
    output logic [NOUT-1:0]            pad_oe
);
    localparam int               NREG      = (NOUT + 7) / 8;
    localparam int               IMG_W     = 8 * NREG;
    localparam int               USED      = NOUT - 8 * (NREG - 1);
    localparam logic [7:0]       LAST_MASK = 8'(8'hFF << (8 - USED));
    localparam logic [IMG_W-1:0] RST_IMG   = {LAST_MASK, {(IMG_W-8){1'b1}}};
    localparam logic [IMG_W-1:0] RSV_MASK  = {~LAST_MASK, {(IMG_W-8){1'b0}}};

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic bus_start, bus_stop, drive_req;

    fcs_line_sync #(.STAGES(SYNC)) u_scl (
        .clk(clk), .rst_n(rst_n), .raw(scl_in),
        .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));
    fcs_line_sync #(.STAGES(SYNC)) u_sda (
        .clk(clk), .rst_n(rst_n), .raw(sda_in),
        .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

    // bus conditions: SDA moving while SCL stays high
    assign bus_start = sda_fall & scl_lvl & ~scl_rise;
    assign bus_stop  = sda_rise & scl_lvl & ~scl_rise;

    fcs_link #(
        .NREG(NREG), .SMB_ADDR(SMB_ADDR), .I2C_ADDR(I2C_ADDR),
        .I2C_DC(I2C_DC), .LAST_MASK(LAST_MASK), .RST_IMG(RST_IMG)
    ) u_link (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .bus_start(bus_start), .bus_stop(bus_stop),
        .drive_req(drive_req), .image(ctl_image));

    fcs_sda_hold #(.HOLD(HOLD)) u_hold (
        .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall),
        .req(drive_req), .sda_pull(sda_pull));

    fcs_gate #(.NOUT(NOUT), .NREG(NREG)) u_gate (
        .ref_clk(ref_clk), .drive_en(drive_en), .image(ctl_image),
        .clk_out(clk_out), .pad_oe(pad_oe));
endmodule

// File: rtl/clk_fanout_ctl_chk.sv
// Checker for clk_fanout_ctl: reset image, reserved bits, commit timing, SDA discipline.
// Assumes: bound into clk_fanout_ctl so its localparams and nets are visible.
module clk_fanout_ctl_chk #(
    parameter int               IMG_W    = 24,
    parameter logic [IMG_W-1:0] RST_IMG  = '1,
    parameter logic [IMG_W-1:0] RSV_MASK = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_lvl,
    input logic             scl_fall,
    input logic             sda_pull,
    input logic [IMG_W-1:0] ctl_image
);
    a_r2_reset_image: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctl_image == RST_IMG && !sda_pull));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_image & RSV_MASK) == '0);

    a_r5_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_image != $past(ctl_image)) |-> $past(scl_fall));

    a_r11_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_lvl);
endmodule

bind clk_fanout_ctl clk_fanout_ctl_chk #(
    .IMG_W(IMG_W), .RST_IMG(RST_IMG), .RSV_MASK(RSV_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
    .sda_pull(sda_pull), .ctl_image(ctl_image));

// File: tb/sim_clk_fanout_ctl.sv
// Bench: bus master tasks, a behavioural register model compared every clock.
module sim_clk_fanout_ctl;
    localparam int Q = 10;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
    logic ref_clk = 1'b0, drive_en = 1'b1;
    logic        sda_pull;
    logic [23:0] img;
    logic [17:0] clk_out, pad_oe;
    wire         sda_line = ~(m_low | sda_pull);

    clk_fanout_ctl u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .ref_clk(ref_clk), .drive_en(drive_en),
        .ctl_image(img), .clk_out(clk_out), .pad_oe(pad_oe));

    always #5 clk = ~clk;

    int total = 0, bad = 0, settle = 0, hc = 0;
    logic [7:0] mreg [0:2];
    logic       prev_pull = 1'b0;
    logic [23:0] eimg;
    logic [17:0] eout;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] msk(input int idx, input logic [7:0] v);
        return (idx == 2) ? (v & 8'hC0) : v;
    endfunction

    // per-clock comparison of image, gated outputs and SDA discipline
    always @(negedge clk) begin
        if (rst_n) begin
            if (settle > 0) settle--;
            else begin
                eimg = {mreg[2], mreg[1], mreg[0]};
                for (int k = 0; k < 18; k++)
                    eout[k] = drive_en & ref_clk & ((k < 16) ? eimg[k] : eimg[k + 6]);
                chk("R3 image vs model", 32'(img), 32'(eimg));
                chk("R10 gated outputs", 32'(clk_out), 32'(eout));
                chk("R10 pad enables", 32'(pad_oe), drive_en ? 32'h3FFFF : 32'h0);
            end
            if (scl) hc++; else hc = 0;
            if (hc > 4) chk("R11 sda stable while scl high", 32'(sda_pull), 32'(prev_pull));
            prev_pull = sda_pull;
        end
    end

    initial begin
        forever begin
            @(posedge clk); #2 ref_clk = ~ref_clk;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic scl_set(input logic v);
        scl = v; settle = 8;
    endtask

    task automatic b_start();
        m_low = 1'b0; tick(Q); scl_set(1'b1); tick(Q);
        m_low = 1'b1; tick(Q); scl_set(1'b0); tick(2);
    endtask

    task automatic b_stop();
        m_low = 1'b1; tick(Q); scl_set(1'b1); tick(Q); m_low = 1'b0; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        tick(2); m_low = ~b; tick(Q); scl_set(1'b1); tick(2 * Q); scl_set(1'b0);
    endtask

    task automatic wr_byte(input logic [7:0] b, input int widx, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        if (widx >= 0) mreg[widx] = msk(widx, b);
        tick(2); m_low = 1'b0; tick(Q); scl_set(1'b1); tick(Q);
        ack = ~sda_line; tick(Q); scl_set(1'b0);
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        tick(2); m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_set(1'b1); tick(Q); b[i] = sda_line; tick(Q); scl_set(1'b0);
        end
        tick(2); m_low = mack; tick(Q); scl_set(1'b1); tick(2 * Q); scl_set(1'b0);
        tick(2); m_low = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        mreg[0] = 8'hFF; mreg[1] = 8'hFF; mreg[2] = 8'hC0;
        tick(6);
        chk("R2 reset image", 32'(img), 32'hC0FFFF);
        chk("R2 reset sda released", 32'(sda_pull), 32'h0);
        rst_n = 1'b1; tick(20);

        // R1 / R4 / R5: pointer-mode random write to register 1
        b_start();
        wr_byte(8'hB0, -1, a); chk("R1 pointer address ack", 32'(a), 32'h1);
        wr_byte(8'h01, -1, a); chk("R4 pointer byte ack", 32'(a), 32'h1);
        wr_byte(8'h5A, 1, a);  chk("R4 data ack", 32'(a), 32'h1);
        tick(Q);
        chk("R5 committed before STOP", 32'(img[15:8]), 32'h5A);
        b_stop();

        // R1 / R3: alternate address with bit 2 set, disable outputs 7..0
        b_start();
        wr_byte(8'hB8, -1, a); chk("R1 alternate address ack", 32'(a), 32'h1);
        wr_byte(8'h00, -1, a);
        wr_byte(8'h00, 0, a);
        b_stop();
        chk("R3 outputs 7..0 held low", 32'(clk_out[7:0]), 32'h0);

        // R4: sequential write with wrap, reserved bits masked
        b_start();
        wr_byte(8'hB0, -1, a); wr_byte(8'h01, -1, a);
        wr_byte(8'h11, 1, a); wr_byte(8'hFF, 2, a); wr_byte(8'h33, 0, a);
        b_stop();
        chk("R4 wrap image", 32'(img), 32'hC01133);

        // R6 / R3: random read of register 2, reserved bits zero
        b_start();
        wr_byte(8'hB0, -1, a); wr_byte(8'h02, -1, a);
        b_start();
        wr_byte(8'hB1, -1, a); chk("R6 read address ack", 32'(a), 32'h1);
        rd_byte(1'b0, d); chk("R6 random read reg2", 32'(d), 32'hC0);
        chk("R6 released after nack", 32'(sda_pull), 32'h0);
        b_stop();

        // R6: sequential read from register 1 with wrap
        b_start();
        wr_byte(8'hB0, -1, a); wr_byte(8'h01, -1, a);
        b_start(); wr_byte(8'hB1, -1, a);
        rd_byte(1'b1, d); chk("R6 seq read 1", 32'(d), 32'h11);
        rd_byte(1'b1, d); chk("R6 seq read 2", 32'(d), 32'hC0);
        rd_byte(1'b1, d); chk("R6 seq read wrap", 32'(d), 32'h33);
        rd_byte(1'b0, d); chk("R6 seq read 4", 32'(d), 32'h11);
        b_stop();

        // R7: block write starts at register 0 regardless of old pointer
        b_start(); wr_byte(8'hB0, -1, a); wr_byte(8'h02, -1, a); b_stop();
        b_start();
        wr_byte(8'hD2, -1, a); chk("R1 block address ack", 32'(a), 32'h1);
        wr_byte(8'h00, -1, a); chk("R7 zero command ack", 32'(a), 32'h1);
        wr_byte(8'h07, -1, a); chk("R7 count ack", 32'(a), 32'h1);
        wr_byte(8'hA1, 0, a); wr_byte(8'hB2, 1, a); wr_byte(8'h7F, 2, a);
        b_stop();
        chk("R7 block write image", 32'(img), 32'h40B2A1);

        // R8: non-zero command refused, later bytes ignored
        b_start();
        wr_byte(8'hD2, -1, a);
        wr_byte(8'h05, -1, a); chk("R8 bad command nack", 32'(a), 32'h0);
        wr_byte(8'h44, -1, a); chk("R8 later byte nack", 32'(a), 32'h0);
        b_stop();
        chk("R8 image unchanged", 32'(img), 32'h40B2A1);

        // R9: block read with count slot
        b_start();
        wr_byte(8'hD2, -1, a); wr_byte(8'h00, -1, a);
        b_start(); wr_byte(8'hD3, -1, a);
        rd_byte(1'b1, d); chk("R9 count slot", 32'(d), 32'h03);
        rd_byte(1'b1, d); chk("R9 block read reg0", 32'(d), 32'hA1);
        rd_byte(1'b1, d); chk("R9 block read reg1", 32'(d), 32'hB2);
        rd_byte(1'b0, d); chk("R9 block read reg2", 32'(d), 32'h40);
        b_stop();

        // R1: unmatched addresses
        b_start();
        wr_byte(8'hA0, -1, a); chk("R1 foreign address nack", 32'(a), 32'h0);
        wr_byte(8'h12, -1, a); chk("R1 ignored byte nack", 32'(a), 32'h0);
        b_stop();
        b_start();
        wr_byte(8'hD0, -1, a); chk("R1 near-miss address nack", 32'(a), 32'h0);
        b_stop();

        // R5: partial byte cut by STOP, then by repeated START
        b_start();
        wr_byte(8'hB0, -1, a); wr_byte(8'h00, -1, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        b_stop();
        chk("R5 partial byte dropped on STOP", 32'(img[7:0]), 32'hA1);
        b_start();
        wr_byte(8'hB0, -1, a); wr_byte(8'h01, -1, a);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        b_start();
        wr_byte(8'hB0, -1, a); wr_byte(8'h01, -1, a); wr_byte(8'h77, 1, a);
        b_stop();
        chk("R5 repeated START drops partial", 32'(img[15:8]), 32'h77);

        // R4: out-of-range pointer loads 0
        b_start();
        wr_byte(8'hB0, -1, a); wr_byte(8'h07, -1, a); wr_byte(8'h5C, 0, a);
        b_stop();
        chk("R4 out-of-range pointer", 32'(img[7:0]), 32'h5C);

        // R10: pads off, then back on
        drive_en = 1'b0; tick(4);
        chk("R10 pads off", 32'(pad_oe), 32'h0);
        chk("R10 outputs quiet", 32'(clk_out), 32'h0);
        drive_en = 1'b1; tick(4);
        chk("R10 pads on", 32'(pad_oe), 32'h3FFFF);
        tick(40);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule